// File: doc/BRIEF.md
# Four-Channel PWM Timer with Pairwise Concatenation

This block generates four pulse-width modulated outputs from one system clock. Each channel has an 8-bit period, an 8-bit duty value, a polarity bit, an enable bit and a 2-bit clock-source select. Two prescaled tick streams, A and B, come from one free-running prescaler counter. A third stream, the scaled clock, passes only every Nth tick of A, where N is held in an 8-bit scale input. Each channel counts ticks of its chosen stream. Its output sits at the active level while the count is below the duty value and at the other level for the rest of the period.

Channels are grouped in pairs: channels 1 and 2 form pair 0, and channels 3 and 4 form pair 1. When a pair's join control is set, its two counters act as one 16-bit counter. The lower-numbered channel supplies the high byte of the period and duty, and the higher-numbered channel supplies the low byte. The higher-numbered channel also supplies the clock select, polarity and enable, and its pin carries the output. Period and duty values are copied into shadow registers only at a period boundary, so software can rewrite them at any time without cutting a pulse short.

Top module: `pwm_quad`

## Requirements
- R1: While reset is asserted, every counter, shadow register, prescaler and join state returns to zero. With all enables low, all pwm_o and pwm_oe_o bits read 0.
- R2: An enabled split channel advances its count by one on each tick of its selected stream. After the tick on which the count equals period-1, the count returns to 0. The output is active while the count is below the shadowed duty value.
- R3: With polarity 1 the active level is high, so the period starts high. With polarity 0 the active level is low, so the period starts low.
- R4: A disabled channel drives pwm_oe_o low and pwm_o low, and it holds its count at 0. On the clock after its enable is set, it starts a period at count 0, using the period and duty values present at that time.
- R5: If the duty value is greater than or equal to a nonzero period value, the output stays at the active level for the whole period. A duty of 0 keeps the output at the inactive level for the whole period.
- R6: A period value of 0 gives 256 ticks in split mode, or 65536 ticks in joined mode.
- R7: New period and duty values are copied to the shadows only when a period ends, or while the channel is disabled.
- R8: When join bit p is set, pair p counts as one 16-bit channel. Its period is {per[2p], per[2p+1]} and its duty is {duty[2p], duty[2p+1]}. Select, polarity and enable come from channel 2p+1, and the output appears on channel 2p+1. Channel 2p drives pwm_o=0 and pwm_oe_o=0.
- R9: When a join bit changes, both counters of that pair restart at 0 on that clock and reload their shadows. The new mode drives the outputs from the next clock.
- R10: Stream A ticks on every cycle in which the low pre_a_i bits of the shared free-running prescaler counter are all ones, which is once every 2^pre_a_i cycles. Stream B does the same with pre_b_i, giving 1 to 128 cycles per tick.
- R11: The scaled stream ticks on every Nth tick of A, where N equals scale_i, and a scale_i of 0 means N = 256.
- R12: The 2-bit select field of channel k is sel_i[2k+1:2k]. The value 0 picks A, 1 picks B, and 2 or 3 picks the scaled stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| cat_i | input | 2 | Join bit per pair (bit p joins channels 2p and 2p+1) |
| sel_i | input | 8 | Clock-source select, 2 bits per channel |
| pre_a_i | input | 2 | Stream A prescale exponent |
| pre_b_i | input | 3 | Stream B prescale exponent |
| scale_i | input | 8 | Scaled-stream divisor (0 = 256) |
| per_i | input | 32 | Period per channel, channel k at bits [8k+7:8k] |
| duty_i | input | 32 | Duty per channel, same layout as per_i |
| pol_i | input | 4 | Polarity per channel |
| en_i | input | 4 | Enable per channel |
| pwm_o | output | 4 | PWM outputs |
| pwm_oe_o | output | 4 | Output-drive enables |

## Verification
A behavioural integer model steps alongside the design on every clock and is compared with all outputs each cycle. The directed phases target several edge cases:
- Duty equal to the period, and duty above it. A strict/non-strict mix-up in the compare would drop a one-cycle glitch at the period end.
- A period of 0. A design that missed the 256-count wrap would stall or produce a one-tick period.
- Period and duty rewrites in the middle of a period. A design without shadow registers would produce a truncated pulse.
- Join toggling in the middle of a period, and joined pairs whose low byte rolls over. A design with the wrong byte order or stale counters would give the wrong 16-bit period or a split first period.
- Odd scale values and large B prescales. These expose an off-by-one in the tick selection.

// File: rtl/pwm_quad_pkg.sv
`timescale 1ns/1ps
package pwm_quad_pkg;

   typedef enum logic [1:0] {
      SRC_A   = 2'd0,
      SRC_B   = 2'd1,
      SRC_SA  = 2'd2,
      SRC_SA2 = 2'd3
   } clk_src_e;

   // Chooses the tick stream named by a channel's select field.
   function automatic logic pick_tick(input logic [1:0] sel, input logic ta,
                                      input logic tb, input logic ts);
      clk_src_e src;
      src = clk_src_e'(sel);
      case (src)
         SRC_A:   return ta;
         SRC_B:   return tb;
         default: return ts;
      endcase
   endfunction

endpackage

// File: rtl/pwm_clkgen.sv
`timescale 1ns/1ps
module pwm_clkgen #(
   parameter int PA_W = 2,
   parameter int PB_W = 3,
   parameter int SC_W = 8
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [PA_W-1:0] pre_a_i,
   input  logic [PB_W-1:0] pre_b_i,
   input  logic [SC_W-1:0] scale_i,
   output logic            tick_a_o,
   output logic            tick_b_o,
   output logic            tick_s_o
);
   localparam int MAX_A = (1 << PA_W) - 1;
   localparam int MAX_B = (1 << PB_W) - 1;
   localparam int PC_W  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam logic [PC_W-1:0] ONES = '1;

   logic [PC_W-1:0] pre_q;
   logic [SC_W-1:0] sc_q;
   logic [PC_W-1:0] mask_a, mask_b;

   assign mask_a   = ~(ONES << pre_a_i);
   assign mask_b   = ~(ONES << pre_b_i);
   assign tick_a_o = (pre_q & mask_a) == mask_a;
   assign tick_b_o = (pre_q & mask_b) == mask_b;
   assign tick_s_o = tick_a_o && (sc_q == scale_i - 1'b1);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pre_q <= '0;
         sc_q  <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
         if (tick_a_o) sc_q <= tick_s_o ? '0 : sc_q + 1'b1;
      end
   end
endmodule

// File: rtl/pwm_pair.sv
`timescale 1ns/1ps
module pwm_pair #(
   parameter int W = 8
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           cat_i,
   input  logic [1:0]     tick_i,
   input  logic [2*W-1:0] per_i,
   input  logic [2*W-1:0] duty_i,
   input  logic [1:0]     pol_i,
   input  logic [1:0]     en_i,
   output logic [1:0]     pwm_o,
   output logic [1:0]     oe_o
);
   // index 0 is the lower-numbered channel (high byte when joined)
   logic [W-1:0]   cnt_q [2];
   logic [W-1:0]   per_q [2];
   logic [W-1:0]   dut_q [2];
   logic           cat_q;
   logic [2*W-1:0] cnt16, per16, dut16, cnt16_nxt;
   logic           wrap16;
   logic [1:0]     wrap8;

   assign cnt16     = {cnt_q[0], cnt_q[1]};
   assign per16     = {per_q[0], per_q[1]};
   assign dut16     = {dut_q[0], dut_q[1]};
   assign wrap16    = tick_i[1] && (cnt16 == per16 - 1'b1);
   assign cnt16_nxt = cnt16 + 1'b1;

   for (genvar k = 0; k < 2; k++) begin : g_wrap
      assign wrap8[k] = tick_i[k] && (cnt_q[k] == per_q[k] - 1'b1);
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cat_q <= 1'b0;
         for (int k = 0; k < 2; k++) begin
            cnt_q[k] <= '0;
            per_q[k] <= '0;
            dut_q[k] <= '0;
         end
      end else begin
         cat_q <= cat_i;
         if (cat_i != cat_q) begin
            for (int k = 0; k < 2; k++) begin
               cnt_q[k] <= '0;
               per_q[k] <= per_i[k*W +: W];
               dut_q[k] <= duty_i[k*W +: W];
            end
         end else if (cat_q) begin
            if (!en_i[1] || wrap16) begin
               for (int k = 0; k < 2; k++) begin
                  cnt_q[k] <= '0;
                  per_q[k] <= per_i[k*W +: W];
                  dut_q[k] <= duty_i[k*W +: W];
               end
            end else if (tick_i[1]) begin
               cnt_q[0] <= cnt16_nxt[2*W-1:W];
               cnt_q[1] <= cnt16_nxt[W-1:0];
            end
         end else begin
            for (int k = 0; k < 2; k++) begin
               if (!en_i[k] || wrap8[k]) begin
                  cnt_q[k] <= '0;
                  per_q[k] <= per_i[k*W +: W];
                  dut_q[k] <= duty_i[k*W +: W];
               end else if (tick_i[k]) begin
                  cnt_q[k] <= cnt_q[k] + 1'b1;
               end
            end
         end
      end
   end

   always_comb begin
      if (cat_q) begin
         pwm_o[0] = 1'b0;
         oe_o[0]  = 1'b0;
         oe_o[1]  = en_i[1];
         pwm_o[1] = en_i[1] & (pol_i[1] ~^ (cnt16 < dut16));
      end else begin
         for (int k = 0; k < 2; k++) begin
            oe_o[k]  = en_i[k];
            pwm_o[k] = en_i[k] & (pol_i[k] ~^ (cnt_q[k] < dut_q[k]));
         end
      end
   end
endmodule

// File: rtl/pwm_quad.sv
`timescale 1ns/1ps
module pwm_quad #(
   parameter int W     = 8,
   parameter int NPAIR = 2,
   parameter int PA_W  = 2,
   parameter int PB_W  = 3,
   parameter int SC_W  = 8,
   localparam int NCH  = 2 * NPAIR
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [NPAIR-1:0] cat_i,
   input  logic [2*NCH-1:0] sel_i,
   input  logic [PA_W-1:0]  pre_a_i,
   input  logic [PB_W-1:0]  pre_b_i,
   input  logic [SC_W-1:0]  scale_i,
   input  logic [NCH*W-1:0] per_i,
   input  logic [NCH*W-1:0] duty_i,
   input  logic [NCH-1:0]   pol_i,
   input  logic [NCH-1:0]   en_i,
   output logic [NCH-1:0]   pwm_o,
   output logic [NCH-1:0]   pwm_oe_o
);
   import pwm_quad_pkg::*;

   if (W < 2 || NPAIR < 1 || PA_W < 1 || PB_W < 1 || SC_W < 1) begin : g_bad_cfg
      $error("pwm_quad: parameter out of range");
   end

   logic           tick_a, tick_b, tick_s;
   logic [NCH-1:0] ch_tick;

   pwm_clkgen #(.PA_W(PA_W), .PB_W(PB_W), .SC_W(SC_W)) u_clkgen (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pre_a_i  (pre_a_i),
      .pre_b_i  (pre_b_i),
      .scale_i  (scale_i),
      .tick_a_o (tick_a),
      .tick_b_o (tick_b),
      .tick_s_o (tick_s)
   );

   for (genvar k = 0; k < NCH; k++) begin : g_sel
      assign ch_tick[k] = pick_tick(sel_i[2*k +: 2], tick_a, tick_b, tick_s);
   end

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      pwm_pair #(.W(W)) u_pair (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .cat_i  (cat_i[p]),
         .tick_i (ch_tick[2*p +: 2]),
         .per_i  (per_i[2*p*W +: 2*W]),
         .duty_i (duty_i[2*p*W +: 2*W]),
         .pol_i  (pol_i[2*p +: 2]),
         .en_i   (en_i[2*p +: 2]),
         .pwm_o  (pwm_o[2*p +: 2]),
         .oe_o   (pwm_oe_o[2*p +: 2])
      );
   end
endmodule

// File: rtl/pwm_quad_chk.sv
`timescale 1ns/1ps
module pwm_quad_chk #(
   parameter int NPAIR = 2,
   parameter int PA_W  = 2,
   localparam int NCH  = 2 * NPAIR
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [NPAIR-1:0] cat_i,
   input logic [PA_W-1:0]  pre_a_i,
   input logic [NCH-1:0]   en_i,
   input logic [NCH-1:0]   pol_i,
   input logic [NCH-1:0]   pwm_o,
   input logic [NCH-1:0]   pwm_oe_o,
   input logic [NCH-1:0]   ch_tick,
   input logic             tick_a,
   input logic             tick_s
);
   p_scaled_subset_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_s |-> tick_a);

   p_prea_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pre_a_i == '0) |-> tick_a);

   for (genvar k = 0; k < NCH; k++) begin : g_ch
      p_off_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !en_i[k] |-> (!pwm_o[k] && !pwm_oe_o[k]));

      p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (en_i[k] && $past(en_i[k]) && $stable(pol_i[k]) && !$past(ch_tick[k])
          && !cat_i[k/2] && !$past(cat_i[k/2]) && !$past(cat_i[k/2], 2))
         |-> $stable(pwm_o[k]));
   end

   for (genvar p = 0; p < NPAIR; p++) begin : g_pr
      p_lo_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (cat_i[p] && $past(cat_i[p])) |-> (!pwm_o[2*p] && !pwm_oe_o[2*p]));

      p_hi_oe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         pwm_oe_o[2*p+1] == en_i[2*p+1]);

      p_split_oe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!cat_i[p] && !$past(cat_i[p])) |-> (pwm_oe_o[2*p] == en_i[2*p]));
   end
endmodule

bind pwm_quad pwm_quad_chk #(.NPAIR(NPAIR), .PA_W(PA_W)) u_pwm_quad_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .cat_i    (cat_i),
   .pre_a_i  (pre_a_i),
   .en_i     (en_i),
   .pol_i    (pol_i),
   .pwm_o    (pwm_o),
   .pwm_oe_o (pwm_oe_o),
   .ch_tick  (ch_tick),
   .tick_a   (tick_a),
   .tick_s   (tick_s)
);

// File: tb/test_pwm_quad.sv
`timescale 1ns/1ps
module test_pwm_quad;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cat = '0;
   logic [7:0]  sel = '0;
   logic [1:0]  pre_a = '0;
   logic [2:0]  pre_b = '0;
   logic [7:0]  scale = '0;
   logic [31:0] per = '0;
   logic [31:0] duty = '0;
   logic [3:0]  pol = '0;
   logic [3:0]  en = '0;
   logic [3:0]  pwm, oe;

   int    n_checks = 0;
   int    n_fail = 0;
   string cur_req = "R1";
   bit    started = 0;

   // model state
   int m_pre, m_sc;
   int m_cnt [4];
   int m_per [4];
   int m_dut [4];
   bit m_catq [2];

   always #4 clk = ~clk;

   pwm_quad i_pwm_quad (
      .clk_i(clk), .rst_ni(rst_n), .cat_i(cat), .sel_i(sel), .pre_a_i(pre_a),
      .pre_b_i(pre_b), .scale_i(scale), .per_i(per), .duty_i(duty),
      .pol_i(pol), .en_i(en), .pwm_o(pwm), .pwm_oe_o(oe));

   function automatic int fld(input logic [31:0] v, input int k);
      return int'(v[8*k +: 8]);
   endfunction

   task automatic reload(input int k);
      m_cnt[k] = 0;
      m_per[k] = fld(per, k);
      m_dut[k] = fld(duty, k);
   endtask

   always @(posedge clk) begin
      started <= 1'b1;
      if (!rst_n) begin
         m_pre = 0; m_sc = 0;
         for (int k = 0; k < 4; k++) begin m_cnt[k] = 0; m_per[k] = 0; m_dut[k] = 0; end
         m_catq[0] = 0; m_catq[1] = 0;
      end else begin
         bit ta, tb, ts;
         bit tk [4];
         int n;
         ta = (m_pre % (1 << pre_a)) == (1 << pre_a) - 1;
         tb = (m_pre % (1 << pre_b)) == (1 << pre_b) - 1;
         n  = (scale == 0) ? 256 : int'(scale);
         ts = ta && (m_sc == n - 1);
         for (int k = 0; k < 4; k++) begin
            int s;
            s = int'(sel[2*k +: 2]);
            tk[k] = (s == 0) ? ta : (s == 1) ? tb : ts;
         end
         m_pre = (m_pre + 1) % 128;
         if (ta) m_sc = ts ? 0 : (m_sc + 1) % 256;
         for (int p = 0; p < 2; p++) begin
            int a, b;
            a = 2 * p; b = 2 * p + 1;
            if (cat[p] != m_catq[p]) begin
               m_catq[p] = cat[p];
               reload(a); reload(b);
            end else if (m_catq[p]) begin
               int c, pe;
               c  = m_cnt[a] * 256 + m_cnt[b];
               pe = m_per[a] * 256 + m_per[b];
               if (pe == 0) pe = 65536;
               if (!en[b] || (tk[b] && c + 1 == pe)) begin
                  reload(a); reload(b);
               end else if (tk[b]) begin
                  c = c + 1;
                  m_cnt[a] = c / 256;
                  m_cnt[b] = c % 256;
               end
            end else begin
               for (int k = a; k <= b; k++) begin
                  int pe;
                  pe = (m_per[k] == 0) ? 256 : m_per[k];
                  if (!en[k] || (tk[k] && m_cnt[k] + 1 == pe)) reload(k);
                  else if (tk[k]) m_cnt[k] = m_cnt[k] + 1;
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (started) begin
         logic [3:0] eo, eoe;
         for (int p = 0; p < 2; p++) begin
            int a, b;
            bit act;
            a = 2 * p; b = 2 * p + 1;
            if (m_catq[p]) begin
               act = (m_cnt[a] * 256 + m_cnt[b]) < (m_dut[a] * 256 + m_dut[b]);
               eo[a] = 0; eoe[a] = 0;
               eoe[b] = en[b];
               eo[b] = en[b] && (pol[b] ? act : !act);
            end else begin
               for (int k = a; k <= b; k++) begin
                  act = m_cnt[k] < m_dut[k];
                  eoe[k] = en[k];
                  eo[k] = en[k] && (pol[k] ? act : !act);
               end
            end
         end
         n_checks++;
         if (pwm !== eo || oe !== eoe) begin
            n_fail++;
            $display("FAIL %s at %0t: pwm_o=%b oe=%b expected pwm_o=%b oe=%b",
                     cur_req, $time, pwm, oe, eo, eoe);
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic run(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic set_ch(input int k, input int p, input int d, input bit pl,
                         input bit e, input int s);
      per[8*k +: 8]  = 8'(p);
      duty[8*k +: 8] = 8'(d);
      pol[k] = pl;
      en[k]  = e;
      sel[2*k +: 2] = 2'(s);
   endtask

   initial begin
      #(8 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      // R1: reset state
      cur_req = "R1";
      run(3);
      @(negedge clk);
      n_checks++;
      if (pwm !== 4'b0 || oe !== 4'b0) begin
         n_fail++;
         $display("FAIL R1: pwm_o=%b oe=%b expected 0000 0000", pwm, oe);
      end
      step();
      rst_n = 1'b1;

      // R2 R3 R12: split channels on all three streams
      cur_req = "R2/R3/R12";
      pre_a = 0; pre_b = 1; scale = 2;
      set_ch(0, 5, 2, 1, 1, 0);
      set_ch(1, 7, 3, 0, 1, 1);
      set_ch(2, 4, 1, 1, 1, 2);
      set_ch(3, 3, 2, 0, 1, 3);
      run(120);

      // R10 R11: slower prescales, odd scale
      step();
      cur_req = "R10/R11";
      pre_a = 2; pre_b = 3; scale = 3;
      run(500);
      step();
      pre_b = 7; sel[3:2] = 2'd1;
      run(800);

      // R5 R6: duty at/above period, zero duty, zero period
      step();
      cur_req = "R5/R6";
      pre_a = 0; pre_b = 0; scale = 3;
      set_ch(0, 4, 4, 1, 1, 0);
      set_ch(1, 3, 9, 0, 1, 1);
      set_ch(2, 6, 0, 1, 1, 2);
      set_ch(3, 0, 100, 1, 1, 0);
      run(700);

      // R7: rewrites in the middle of a period
      step();
      cur_req = "R7";
      set_ch(0, 9, 5, 1, 1, 0);
      set_ch(3, 10, 2, 0, 1, 0);
      run(3);
      step();
      set_ch(0, 6, 1, 1, 1, 0);
      duty[8*3 +: 8] = 8'd7;
      run(100);

      // R4: disable and re-enable
      step();
      cur_req = "R4";
      en[1] = 0; en[2] = 0;
      run(20);
      step();
      per[8*1 +: 8] = 8'd5; duty[8*1 +: 8] = 8'd1;
      en[1] = 1; en[2] = 1;
      run(60);

      // R8: joined pairs
      step();
      cur_req = "R8";
      pre_b = 1;
      set_ch(0, 1, 0, 0, 1, 0);
      set_ch(1, 4, 200, 1, 1, 0);
      set_ch(2, 0, 0, 0, 0, 0);
      set_ch(3, 3, 1, 0, 1, 1);
      cat = 2'b11;
      run(700);
      step();
      set_ch(2, 1, 1, 0, 0, 2);
      set_ch(3, 2, 0, 1, 1, 1);
      run(900);

      // R7 in joined mode: mid-period duty change
      step();
      cur_req = "R7";
      duty[8*1 +: 8] = 8'd10;
      duty[8*0 +: 8] = 8'd1;
      run(700);

      // R9: join toggled mid-period
      step();
      cur_req = "R9";
      cat[0] = 0;
      run(37);
      step();
      cat[1] = 0;
      run(40);
      step();
      cat = 2'b11;
      run(300);

      // R6 joined: zero period, short run
      step();
      cur_req = "R6";
      per[15:0] = 16'h0000; duty[15:0] = 16'h0003;
      run(300);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule